// File: doc/BRIEF.md
# Factory Bad-Block Table Scanner

This block builds a table of factory-marked bad erase blocks for a NAND array. After a start pulse it walks the erase blocks in ascending order through a single-byte page-read port. It fetches the first spare byte of a block's first page and, only when that byte is FFh, the same byte of the second page. Any other value marks the block bad in a one-bit-per-block register table. Block 0 is guaranteed good by the device, so the scan records it as good without reading it.

The read port is a request/acknowledge handshake. The scanner holds a row address and a column address with the request until the responder acknowledges, and the returned byte is taken in the acknowledge cycle. While the scan runs and after it ends, the table can be read by block index through a combinational lookup. A saturating counter reports how many blocks were found bad, and a done flag rises once the last block is judged. A new start pulse clears the table and the count at any time and runs the scan again from the beginning.

Top module: `nand_badblk_scan`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o` and `done_o` are 0, `bad_cnt_o` is 0 and every table entry reads 0 (good).
- R2: Every read request carries column `MARKER_COL` (2048 by default) and row `block*PAGES + page`, where page is 0 or 1 (`PAGES` is 64 by default).
- R3: Block 0 is never read and always reads back as good after a scan.
- R4: For each block, page 0 is read first. Page 1 of the same block is requested directly after page 0 only when the page-0 byte is FFh. Otherwise the scan moves to the next block.
- R5: A table entry reads 1 (bad) exactly when the block's page-0 byte, or its page-1 byte when read, is anything other than FFh. A byte with a single 0 bit counts as bad.
- R6: Blocks are visited once each, in ascending order from block 1 to block `NUM_BLOCKS-1`. After the last block is judged, `done_o` is 1, `busy_o` is 0 and no request is raised.
- R7: `bad_cnt_o` equals the number of bad blocks found, saturating at `2**CNT_W-1`.
- R8: A start pulse, also in the middle of a scan, clears the table, the count and `done_o` in the cycle after it is sampled, and restarts the walk at block 1.
- R9: While a request is waiting for its acknowledge, the request and both addresses stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: clear table and count, start the scan |
| rd_req_o | output | 1 | Read request to the page-read port |
| rd_row_o | output | ROW_W | Row (page) address of the request |
| rd_col_o | output | COL_W | Column address of the request |
| rd_ack_i | input | 1 | Read acknowledge, data valid in this cycle |
| rd_data_i | input | 8 | Byte returned with the acknowledge |
| tbl_idx_i | input | BLK_W | Block index for table lookup |
| tbl_bad_o | output | 1 | Table entry at `tbl_idx_i`, 1 = bad |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished |
| bad_cnt_o | output | CNT_W | Saturating count of bad blocks |

## Verification
The hardest situation to reach from the ports is a restart that lands while a request is still waiting for its acknowledge. There, a late acknowledge must not leak into the new scan, and a stale table entry must not survive. The bench responder answers with a varying latency of zero to two cycles. The bench raises a start pulse after a few reads of one bad-block pattern, switches the responder to another pattern, and then compares the whole read sequence, the table and the count against the second pattern alone. A pattern with more bad blocks than the counter can hold drives the count into saturation.

// File: rtl/nbbt_pkg.sv
package nbbt_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_PG0  = 2'd1,
      S_PG1  = 2'd2,
      S_DONE = 2'd3
   } scan_state_t;
endpackage

// File: rtl/nbbt_marker.sv
module nbbt_marker #(
   parameter logic [7:0] GOOD_VAL  = 8'hFF,
   parameter bit         EXACT_CMP = 1'b1
) (
   input  logic [7:0] data_i,
   output logic       good_o
);
   generate
      if (EXACT_CMP) begin : g_exact
         assign good_o = (data_i == GOOD_VAL);
      end else begin : g_masked
         assign good_o = ((data_i & GOOD_VAL) == GOOD_VAL);
      end
   endgenerate
endmodule

// File: rtl/nbbt_seq.sv
module nbbt_seq
   import nbbt_pkg::*;
#(
   parameter int NUM_BLOCKS  = 1024,
   parameter bit TRUST_FIRST = 1'b1,
   localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             ack_i,
   input  logic             good_i,
   output logic             req_o,
   output logic [BLK_W-1:0] blk_o,
   output logic             page_o,
   output logic             mark_o,
   output logic             busy_o,
   output logic             done_o
);
   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

   scan_state_t      state_q;
   logic [BLK_W-1:0] blk_q;
   logic [BLK_W-1:0] first_blk;
   logic             reading;
   logic             judged_bad;

   generate
      if (TRUST_FIRST) begin : g_skip_first
         assign first_blk = BLK_W'(1);
      end else begin : g_scan_first
         assign first_blk = '0;
      end
   endgenerate

   assign reading    = (state_q == S_PG0) || (state_q == S_PG1);
   assign judged_bad = reading && ack_i && !good_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= S_IDLE;
         blk_q   <= '0;
      end else if (start_i) begin
         state_q <= S_PG0;
         blk_q   <= first_blk;
      end else if (reading && ack_i) begin
         if (state_q == S_PG0 && good_i) begin
            state_q <= S_PG1;
         end else if (blk_q == LAST_BLK) begin
            state_q <= S_DONE;
         end else begin
            state_q <= S_PG0;
            blk_q   <= blk_q + 1'b1;
         end
      end
   end

   assign req_o  = reading;
   assign blk_o  = blk_q;
   assign page_o = (state_q == S_PG1);
   assign mark_o = judged_bad && !start_i;
   assign busy_o = reading;
   assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/nbbt_table.sv
module nbbt_table #(
   parameter int NUM_BLOCKS = 1024,
   localparam int BLK_W     = $clog2(NUM_BLOCKS),
   localparam int DEPTH     = 1 << BLK_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             set_i,
   input  logic [BLK_W-1:0] set_idx_i,
   input  logic [BLK_W-1:0] rd_idx_i,
   output logic             rd_bad_o
);
   logic [NUM_BLOCKS-1:0] bad_q;
   logic [DEPTH-1:0]      padded;

   generate
      for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_entry
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               bad_q[i] <= 1'b0;
            end else if (clr_i) begin
               bad_q[i] <= 1'b0;
            end else if (set_i && (set_idx_i == BLK_W'(i))) begin
               bad_q[i] <= 1'b1;
            end
         end
      end
   endgenerate

   assign padded   = DEPTH'(bad_q);
   assign rd_bad_o = padded[rd_idx_i];
endmodule

// File: rtl/nbbt_satcnt.sv
module nbbt_satcnt #(
   parameter int W = 11
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] MAX_VAL = '1;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != MAX_VAL)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/nand_badblk_scan.sv
module nand_badblk_scan #(
   parameter int NUM_BLOCKS  = 1024,
   parameter int PAGES       = 64,
   parameter int COL_W       = 12,
   parameter int MARKER_COL  = 2048,
   parameter int CNT_W       = $clog2(NUM_BLOCKS + 1),
   parameter bit TRUST_FIRST = 1'b1,
   localparam int BLK_W      = $clog2(NUM_BLOCKS),
   localparam int PG_W       = $clog2(PAGES),
   localparam int ROW_W      = BLK_W + PG_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             rd_req_o,
   output logic [ROW_W-1:0] rd_row_o,
   output logic [COL_W-1:0] rd_col_o,
   input  logic             rd_ack_i,
   input  logic [7:0]       rd_data_i,
   input  logic [BLK_W-1:0] tbl_idx_i,
   output logic             tbl_bad_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [CNT_W-1:0] bad_cnt_o
);
   generate
      if (NUM_BLOCKS < 2) begin : g_err_blocks
         $error("NUM_BLOCKS must be at least 2");
      end
      if (PAGES < 2 || (1 << PG_W) != PAGES) begin : g_err_pages
         $error("PAGES must be a power of two of at least 2");
      end
      if (MARKER_COL >= (1 << COL_W)) begin : g_err_col
         $error("MARKER_COL does not fit in COL_W bits");
      end
      if (CNT_W < 1) begin : g_err_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic             byte_good;
   logic [BLK_W-1:0] cur_blk;
   logic             cur_page;
   logic             mark_bad;

   nbbt_marker #(
      .GOOD_VAL (8'hFF),
      .EXACT_CMP(1'b1)
   ) u_marker (
      .data_i(rd_data_i),
      .good_o(byte_good)
   );

   nbbt_seq #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .TRUST_FIRST(TRUST_FIRST)
   ) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .ack_i  (rd_ack_i),
      .good_i (byte_good),
      .req_o  (rd_req_o),
      .blk_o  (cur_blk),
      .page_o (cur_page),
      .mark_o (mark_bad),
      .busy_o (busy_o),
      .done_o (done_o)
   );

   nbbt_table #(
      .NUM_BLOCKS(NUM_BLOCKS)
   ) u_table (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (start_i),
      .set_i    (mark_bad),
      .set_idx_i(cur_blk),
      .rd_idx_i (tbl_idx_i),
      .rd_bad_o (tbl_bad_o)
   );

   nbbt_satcnt #(
      .W(CNT_W)
   ) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .inc_i (mark_bad),
      .cnt_o (bad_cnt_o)
   );

   assign rd_row_o = (ROW_W'(cur_blk) << PG_W) | ROW_W'(cur_page);
   assign rd_col_o = COL_W'(MARKER_COL);
endmodule

// File: rtl/nand_badblk_scan_chk.sv
module nand_badblk_scan_chk #(
   parameter int NUM_BLOCKS = 1024,
   parameter int PAGES      = 64,
   parameter int COL_W      = 12,
   parameter int MARKER_COL = 2048,
   parameter int CNT_W      = 11,
   localparam int BLK_W     = $clog2(NUM_BLOCKS),
   localparam int PG_W      = $clog2(PAGES),
   localparam int ROW_W     = BLK_W + PG_W
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             rd_req_o,
   input logic [ROW_W-1:0] rd_row_o,
   input logic [COL_W-1:0] rd_col_o,
   input logic             rd_ack_i,
   input logic [7:0]       rd_data_i,
   input logic [BLK_W-1:0] tbl_idx_i,
   input logic             tbl_bad_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [CNT_W-1:0] bad_cnt_o
);
   logic [PG_W-1:0] pg;
   logic            acc;
   assign pg  = rd_row_o[PG_W-1:0];
   assign acc = rd_req_o && rd_ack_i && !start_i;

   // R2: marker column and page 0 or 1 only
   p_addr_field_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o |-> (rd_col_o == COL_W'(MARKER_COL)) && (pg <= PG_W'(1)));

   // R3: block 0 is never requested
   p_skip_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o |-> (rd_row_o >= ROW_W'(PAGES)));

   // R4: good page-0 byte leads straight to page 1 of the same block
   p_page1_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && pg == '0 && rd_data_i == 8'hFF) |=>
         (rd_req_o && rd_row_o == ROW_W'($past(rd_row_o) + 1'b1)));

   // R4: bad page-0 byte never leads to a page-1 read
   p_page1_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && pg == '0 && rd_data_i != 8'hFF) |=> (!rd_req_o || pg == '0));

   // R6: finished scan is quiet
   p_done_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!rd_req_o && !busy_o));

   // R7: count never falls without a start
   p_cnt_mono_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (bad_cnt_o >= $past(bad_cnt_o)));

   // R8: start clears count, done and table
   p_start_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (bad_cnt_o == '0 && !done_o && !tbl_bad_o));

   // R9: waiting request keeps its address
   p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_o && !rd_ack_i && !start_i) |=>
         (rd_req_o && $stable(rd_row_o) && $stable(rd_col_o)));
endmodule

bind nand_badblk_scan nand_badblk_scan_chk #(
   .NUM_BLOCKS(NUM_BLOCKS),
   .PAGES     (PAGES),
   .COL_W     (COL_W),
   .MARKER_COL(MARKER_COL),
   .CNT_W     (CNT_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .rd_req_o (rd_req_o),
   .rd_row_o (rd_row_o),
   .rd_col_o (rd_col_o),
   .rd_ack_i (rd_ack_i),
   .rd_data_i(rd_data_i),
   .tbl_idx_i(tbl_idx_i),
   .tbl_bad_o(tbl_bad_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .bad_cnt_o(bad_cnt_o)
);

// File: tb/nand_badblk_scan_tb_top.sv
`timescale 1ns/1ps
module nand_badblk_scan_tb_top;
   localparam int NB    = 12;
   localparam int PG    = 64;
   localparam int CW    = 12;
   localparam int MCOL  = 2048;
   localparam int CNTW  = 3;
   localparam int BW    = $clog2(NB);
   localparam int RW    = BW + $clog2(PG);
   localparam int CMAX  = (1 << CNTW) - 1;
   localparam int NVEC  = 4;
   // each vector: {page-0 bad mask, page-1 bad mask}, bit b = block b
   localparam logic [23:0] VEC [NVEC] = '{
      {12'h000, 12'h000},
      {12'h089, 12'h820},
      {12'h004, 12'h006},
      {12'hFFF, 12'h000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rd_req;
   logic [RW-1:0] rd_row;
   logic [CW-1:0] rd_col;
   logic          rd_ack = 1'b0;
   logic [7:0]    rd_data = 8'h00;
   logic [BW-1:0] tbl_idx = '0;
   logic          tbl_bad;
   logic          busy;
   logic          done;
   logic [CNTW-1:0] bad_cnt;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [11:0] m0 = '0;
   logic [11:0] m1 = '0;
   logic [RW-1:0] log_row [64];
   int log_n = 0;
   int wait_cnt = 0;
   int dly = 0;
   logic [RW-1:0] first_row = '0;

   always #10 clk = ~clk;

   nand_badblk_scan #(
      .NUM_BLOCKS(NB), .PAGES(PG), .COL_W(CW), .MARKER_COL(MCOL), .CNT_W(CNTW)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .rd_req_o(rd_req), .rd_row_o(rd_row), .rd_col_o(rd_col),
      .rd_ack_i(rd_ack), .rd_data_i(rd_data),
      .tbl_idx_i(tbl_idx), .tbl_bad_o(tbl_bad),
      .busy_o(busy), .done_o(done), .bad_cnt_o(bad_cnt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_byte(input int b, input int p);
      logic hit;
      hit = (p == 0) ? m0[b] : m1[b];
      return hit ? ~(8'h01 << (b % 8)) : 8'hFF;
   endfunction

   // responder: variable latency, acknowledges at negedge
   always @(negedge clk) begin
      if (rd_ack) begin
         rd_ack <= 1'b0;
      end else if (start || !rd_req) begin
         wait_cnt <= 0;
      end else begin
         if (wait_cnt == 0) first_row <= rd_row;
         if (wait_cnt >= dly) begin
            chk((wait_cnt == 0) || (rd_row == first_row), "R9 address held while waiting",
                int'(rd_row), int'(first_row));
            chk(rd_col == CW'(MCOL), "R2 column", int'(rd_col), MCOL);
            rd_ack  <= 1'b1;
            rd_data <= model_byte(int'(rd_row) / PG, int'(rd_row) % PG);
            if (log_n < 64) log_row[log_n] = rd_row;
            log_n++;
            wait_cnt <= 0;
            dly <= (dly + 1) % 3;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   task automatic pulse_start();
      @(posedge clk); #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      log_n = 0;
   endtask

   task automatic verify_scan(input string name);
      int exp_cnt = 0;
      int k = 0;
      while (!done) @(posedge clk);
      #2;
      chk(done && !busy && !rd_req, {"R6 done/quiet ", name}, int'({done, busy, rd_req}), 4);
      for (int b = 0; b < NB; b++) begin
         logic exp_bad;
         exp_bad = (b != 0) && (m0[b] || (!m0[b] && m1[b]));
         if (exp_bad) exp_cnt++;
         tbl_idx = BW'(b);
         #1;
         chk(tbl_bad == exp_bad, (b == 0) ? {"R3 block0 ", name} : {"R5 table ", name},
             int'(tbl_bad), int'(exp_bad));
      end
      if (exp_cnt > CMAX) exp_cnt = CMAX;
      chk(int'(bad_cnt) == exp_cnt, {"R7 count ", name}, int'(bad_cnt), exp_cnt);
      for (int b = 1; b < NB; b++) begin
         for (int p = 0; p < 2; p++) begin
            if (p == 0 || !m0[b]) begin
               chk(k < log_n && log_row[k] == RW'(b * PG + p), {"R2/R4/R6 read order ", name},
                   (k < log_n) ? int'(log_row[k]) : -1, b * PG + p);
               k++;
            end
         end
      end
      chk(log_n == k, {"R4 read count ", name}, log_n, k);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected done", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(!rd_req, "R1 req after reset", int'(rd_req), 0);
      chk(!busy && !done, "R1 busy/done after reset", int'({busy, done}), 0);
      chk(bad_cnt == '0, "R1 count after reset", int'(bad_cnt), 0);
      for (int b = 0; b < NB; b++) begin
         tbl_idx = BW'(b); #1;
         chk(!tbl_bad, "R1 table after reset", int'(tbl_bad), 0);
      end

      for (int v = 0; v < NVEC; v++) begin
         m0 = VEC[v][23:12];
         m1 = VEC[v][11:0];
         pulse_start();
         verify_scan($sformatf("vec%0d", v));
      end

      // R8: restart after a finished scan (vector 3 left bad blocks)
      pulse_start();
      tbl_idx = BW'(5); #1;
      chk(bad_cnt == '0 && !done, "R8 clear after start", int'({done, bad_cnt}), 0);
      chk(!tbl_bad, "R8 table cleared", int'(tbl_bad), 0);

      // R8: restart in the middle of a scan with a new pattern
      m0 = VEC[1][23:12]; m1 = VEC[1][11:0];
      while (log_n < 4) @(posedge clk);
      #2 m0 = VEC[2][23:12]; m1 = VEC[2][11:0];
      pulse_start();
      verify_scan("mid-scan restart R8");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule